// File: doc/BRIEF.md
# Maximal-Length Pseudo-Random Sequence Generator

This block is a free-running shift-register sequence generator. Its single output shows the register contents and moves to a new pseudo-random value on every rising clock edge that is not a reset cycle. The register is WIDTH bits wide. Its feedback taps come from a primitive polynomial for that width, so the sequence has the longest period possible for the register.

A build-time switch, ZERO_INSERT, picks one of two sequences. With the switch off, the register visits every nonzero pattern once per period, and the period is 2^WIDTH−1. With the switch on, the all-zero pattern is spliced in between the pattern that has only the top bit set and the pattern that has only the bottom bit set, and the period becomes exactly 2^WIDTH. A synchronous reset loads the all-ones pattern, which is the first value of the sequence.

The generator suits test-pattern generation, scrambling and cheap address walks. It has no enable input and no seed input, and its taps are fixed when it is built.

Top module: `lfsr_maxlen`

## Requirements
- R1: The width is the parameter WIDTH, default 8, with supported values from 3 to 16. The output `lfsr_q` shows the full register at all times.
- R2: When `rst` is high at a rising edge of `clk`, the register loads all ones. Reset takes priority over stepping, including the cycles in which the zero splice would occur.
- R3: At each rising edge with `rst` low, the register shifts one place toward the MSB: new bits [WIDTH-1:1] equal old bits [WIDTH-2:0].
- R4: With ZERO_INSERT=0, the output first returns to all ones exactly 2^WIDTH−1 edges after reset is released. This holds for both WIDTH=8 and WIDTH=4.
- R5: With ZERO_INSERT=0, the output is never zero, and no value repeats within one period.
- R6: With ZERO_INSERT=1, the output first returns to all ones exactly 2^WIDTH edges after reset is released.
- R7: With ZERO_INSERT=1, zero appears exactly once per period. Zero is entered only from the value with just bit WIDTH-1 set, and it is always followed by the value 1.
- R8: With ZERO_INSERT=1, no value repeats within one period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the register steps on every edge |
| rst | input | 1 | Synchronous active-high reset; loads all ones |
| lfsr_q | output | WIDTH | Current register contents |

## Verification
Two things can fall on the same edge: reset, and the zero splice. In zero-insertion mode the splice redirects the feedback when the register holds the top-bit-only value or zero, and reset can be asserted in either of those cycles. The bench steps the zero-inserting instance until it reaches each of those two values and raises reset for that edge. It then judges the result at the next falling edge: the register must show all ones, not zero and not one. The bench also sweeps full periods of three configurations (8-bit standard, 8-bit zero-inserting and 4-bit standard) and compares the return distance, the distinctness of the values and the splice transitions with figures it computes itself.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int MIN_WIDTH = 3;
  localparam int MAX_WIDTH = 16;

  // Feedback tap mask: bit (t-1) is set for each tap t of a primitive polynomial.
  function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
    case (width)
      3:       tap_mask = 16'h0006;
      4:       tap_mask = 16'h000C;
      5:       tap_mask = 16'h0014;
      6:       tap_mask = 16'h0030;
      7:       tap_mask = 16'h0060;
      8:       tap_mask = 16'h00B8;
      9:       tap_mask = 16'h0110;
      10:      tap_mask = 16'h0240;
      11:      tap_mask = 16'h0500;
      12:      tap_mask = 16'h0829;
      13:      tap_mask = 16'h100D;
      14:      tap_mask = 16'h2015;
      15:      tap_mask = 16'h6000;
      16:      tap_mask = 16'hD008;
      default: tap_mask = 16'h0000;
    endcase
  endfunction

  // Sequence length for a given width and splice choice.
  function automatic int seq_period(input int width, input bit zero_insert);
    seq_period = (1 << width) - (zero_insert ? 0 : 1);
  endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int WIDTH       = 8,
  parameter bit ZERO_INSERT = 1'b0
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb,
  output logic             splice
);
  localparam logic [lfsr_pkg::MAX_WIDTH-1:0] MASK_FULL = lfsr_pkg::tap_mask(WIDTH);
  localparam logic [WIDTH-1:0]               MASK      = MASK_FULL[WIDTH-1:0];

  logic parity;

  assign parity = ^(state & MASK);
  // Window detector: all bits below the MSB are clear.
  assign splice = (state[WIDTH-2:0] == '0);

  generate
    if (ZERO_INSERT) begin : g_zero_ins
      assign fb = parity ^ splice;
    end else begin : g_plain
      assign fb = parity;
    end
  endgenerate

endmodule

// File: rtl/lfsr_shift_reg.sv
module lfsr_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb,
  output logic [WIDTH-1:0] state,
  output logic             armed
);
  localparam logic [WIDTH-1:0] SEED = '1;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R2
  reset_seed_chk: assert property (@(posedge clk) rst |=> (state == SEED));

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

endmodule

// File: rtl/lfsr_maxlen.sv
module lfsr_maxlen #(
  parameter int WIDTH       = 8,
  parameter bit ZERO_INSERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] lfsr_q
);
  localparam int              PERIOD = lfsr_pkg::seq_period(WIDTH, ZERO_INSERT);
  localparam logic [WIDTH-1:0] SEED  = '1;
  localparam logic [WIDTH-1:0] TOPONE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ONE    = {{(WIDTH-1){1'b0}}, 1'b1};

  generate
    if (WIDTH < lfsr_pkg::MIN_WIDTH || WIDTH > lfsr_pkg::MAX_WIDTH) begin : g_bad_width
      $error("lfsr_maxlen: WIDTH outside supported range");
    end
  endgenerate

  logic             fb;
  logic             splice;
  logic             armed;
  logic [WIDTH-1:0] state;

  lfsr_feedback #(.WIDTH(WIDTH), .ZERO_INSERT(ZERO_INSERT)) u_fb (
    .state (state),
    .fb    (fb),
    .splice(splice)
  );

  lfsr_shift_reg #(.WIDTH(WIDTH)) u_reg (
    .clk  (clk),
    .rst  (rst),
    .fb   (fb),
    .state(state),
    .armed(armed)
  );

  assign lfsr_q = state;

  // Distance since the register last held the seed, for the period checks.
  logic [WIDTH:0] since_seed;
  always_ff @(posedge clk) begin
    if (rst)                since_seed <= '0;
    else if (state == SEED) since_seed <= {{WIDTH{1'b0}}, 1'b1};
    else                    since_seed <= since_seed + 1'b1;
  end

  // R4 R6
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && state == SEED && since_seed != '0) |-> (since_seed == PERIOD[WIDTH:0]));

  generate
    if (ZERO_INSERT) begin : g_zi_chk
      // R7
      zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && splice && state == TOPONE) |=> (state == '0));
      // R7
      zero_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && splice && !state[WIDTH-1]) |=> (state == ONE));
    end else begin : g_std_chk
      // R5
      never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && splice) |-> state[WIDTH-1]);
    end
  endgenerate

endmodule

// File: tb/lfsr_maxlen_tb.sv
module lfsr_maxlen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] q8s;
  logic [7:0] q8z;
  logic [3:0] q4s;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_maxlen #(.WIDTH(8), .ZERO_INSERT(1'b0)) u_dut    (.clk(clk), .rst(rst), .lfsr_q(q8s));
  lfsr_maxlen #(.WIDTH(8), .ZERO_INSERT(1'b1)) u_dut_zi (.clk(clk), .rst(rst), .lfsr_q(q8z));
  lfsr_maxlen #(.WIDTH(4), .ZERO_INSERT(1'b0)) u_dut_w4 (.clk(clk), .rst(rst), .lfsr_q(q4s));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-step bookkeeping for one instance.
  task automatic track(input int k, input int w, input int period, input bit zi,
                       input logic [7:0] cur, inout logic [7:0] prev,
                       inout logic [255:0] seen, inout int first_ret,
                       inout int dups, inout int zeros, inout int shift_bad,
                       inout int splice_bad);
    logic [7:0] m;
    logic [7:0] seed;
    m    = 8'((1 << w) - 1);
    seed = m;
    if (((cur >> 1) & (m >> 1)) != (prev & (m >> 1))) shift_bad++;
    if (zi && prev == 8'(1 << (w - 1)) && cur != 8'd0) splice_bad++;
    if (zi && prev == 8'd0 && cur != 8'd1) splice_bad++;
    if (k <= period && cur == 8'd0) zeros++;
    if (first_ret == 0) begin
      if (cur == seed) first_ret = k;
      else begin
        if (seen[cur]) dups++;
        seen[cur] = 1'b1;
      end
    end
    prev = cur;
  endtask

  initial begin
    logic [7:0]   p_s, p_z, p_4;
    logic [255:0] s_s, s_z, s_4;
    int r_s, r_z, r_4;
    int d_s, d_z, d_4;
    int z_s, z_z, z_4;
    int sh_s, sh_z, sh_4;
    int sp_s, sp_z, sp_4;
    int guard;

    r_s = 0; r_z = 0; r_4 = 0; d_s = 0; d_z = 0; d_4 = 0;
    z_s = 0; z_z = 0; z_4 = 0; sh_s = 0; sh_z = 0; sh_4 = 0;
    sp_s = 0; sp_z = 0; sp_4 = 0;
    s_s = '0; s_z = '0; s_4 = '0;

    @(negedge clk);
    @(negedge clk);
    // R1 R2: reset value is all ones at the full width
    check("R2 reset 8-bit std", int'(q8s), 255);
    check("R2 reset 8-bit zi", int'(q8z), 255);
    check("R1 R2 reset 4-bit", int'(q4s), 15);
    p_s = q8s; p_z = q8z; p_4 = {4'd0, q4s};
    s_s[255] = 1'b1; s_z[255] = 1'b1; s_4[15] = 1'b1;
    rst = 1'b0;

    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      track(k, 8, 255, 1'b0, q8s, p_s, s_s, r_s, d_s, z_s, sh_s, sp_s);
      track(k, 8, 256, 1'b1, q8z, p_z, s_z, r_z, d_z, z_z, sh_z, sp_z);
      track(k, 4, 15, 1'b0, {4'd0, q4s}, p_4, s_4, r_4, d_4, z_4, sh_4, sp_4);
    end

    check("R3 shift 8-bit std", sh_s, 0);
    check("R3 shift 8-bit zi", sh_z, 0);
    check("R3 shift 4-bit", sh_4, 0);
    check("R4 period 8-bit std", r_s, (1 << 8) - 1);
    check("R4 period 4-bit std", r_4, (1 << 4) - 1);
    check("R5 zeros 8-bit std", z_s, 0);
    check("R5 zeros 4-bit std", z_4, 0);
    check("R5 repeats 8-bit std", d_s, 0);
    check("R5 repeats 4-bit std", d_4, 0);
    check("R6 period 8-bit zi", r_z, 1 << 8);
    check("R7 zeros per period zi", z_z, 1);
    check("R7 splice transitions zi", sp_z, 0);
    check("R8 repeats 8-bit zi", d_z, 0);

    // R2 with splice: reset while at the top-only value
    guard = 0;
    while (q8z != 8'h80 && guard < 300) begin @(negedge clk); guard++; end
    check("R7 reached top-only value", int'(q8z), 128);
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset beats splice entry", int'(q8z), 255);
    rst = 1'b0;

    // R2 with splice: reset while at zero
    guard = 0;
    while (q8z != 8'h00 && guard < 300) begin @(negedge clk); guard++; end
    check("R7 reached zero", int'(q8z), 0);
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset beats splice exit", int'(q8z), 255);
    check("R2 reset std during run", int'(q8s), 255);
    rst = 1'b0;
    @(negedge clk);
    // R3: first step from all ones shifts a one into bits above bit 0
    check("R3 first step upper bits", int'(q8s[7:1]), 127);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule